// File: doc/BRIEF.md
# Proof-of-Work Nonce Search Engine

This block takes a 640-bit block header and a 32-bit difficulty mask from a word-write port. Once every word has arrived, it runs an autonomous search. For each candidate nonce it writes the nonce into the header, pads the header to a 1024-bit message and hashes it with its own SHA-256 core, one round per clock. The core processes two 512-bit compression blocks, and the second block continues from the chaining value left by the first. The top 32 bits of the digest are then tested against the mask.

The search stops at the first candidate whose digest has zeros at every bit position set in the mask. The block then holds a done flag, a found flag, the nonce word that was hashed and the full 256-bit digest. If the whole nonce field is exhausted without a match, it stops with done set and found clear. Any write to a header address during a search, or after one has finished, abandons the old job and begins collecting a new header.

Top module: `pow_nonce_search`

## Requirements
- R1: The write port decodes addresses 0 to 20. Addresses 0 to 19 are header words. Address 20 is the difficulty mask. A write to any address from 21 upward is ignored entirely: it neither counts towards a load nor disturbs a running search.
- R2: The search starts only when all 21 addresses have each been written at least once since the last start or abort, in any order. `busy` rises in the cycle after the completing write. Rewriting an address that is already held does not complete the set.
- R3: Candidates are tried in increasing order, starting from 0. Each candidate takes exactly 133 clock cycles. After a launch that is followed by candidates 0 to n, `done` rises 133·(n+1) cycles after the launching edge, and `busy` is high for that whole interval.
- R4: The message hashed for a candidate is made of 20 header words followed by padding. Block one is words 0 to 15. Block two is words 16, 17, 18, the nonce word, 0x80000000, nine zero words, 0x00000000 and 0x00000280 (a length of 640 bits). The nonce word is loaded word 19 with its low NONCE_W bits replaced by the candidate. The digest is standard SHA-256 of this message.
- R5: A candidate matches when (digest[255:224] AND mask) equals zero. On the first match, `found` is 1, `nonce_o` carries the nonce word that was hashed and `digest_o` carries its digest.
- R6: If candidate 2^NONCE_W−1 does not match, the search ends with `done` = 1 and `found` = 0, and the low NONCE_W bits of `nonce_o` are all ones.
- R7: Once `done` is high, it stays high, `busy` stays low and `found`, `nonce_o` and `digest_o` hold their values until a write to address 0 to 20 arrives.
- R8: A write to address 0 to 20 while `busy` or `done` is high clears `busy`, `done` and `found` in the next cycle. That write counts as the first word of a fresh load.
- R9: While reset is low, `busy`, `done` and `found` are 0.
- R10: `busy` and `done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | ADDR_W (5) | Word address: 0–19 header, 20 mask |
| wr_data | input | 32 | Word value |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished (match or exhaustion) |
| found | output | 1 | Finished search ended on a match |
| nonce_o | output | 32 | Nonce word of the last candidate hashed |
| digest_o | output | 256 | SHA-256 digest of the last candidate |

## Verification
Several rules are checked by assertions on every cycle:
- `busy` and `done` are mutually exclusive.
- `busy` rises only after a completing load.
- A header write during a search or after it clears the result.
- The done state is held still.
- A reported match really satisfies the mask.
- A not-found result carries an all-ones nonce field.
- The nonce steps by at most one.

Whether the digest is the correct SHA-256 of the padded message, and whether it is the first matching nonce, can only be shown by the bench scenarios. There, an independent hash model searches the same header and predicts the exact cycle when `done` rises. The same applies to the 133-cycle candidate period and to completion of a load by distinct addresses in any order.

// File: rtl/pow_pkg.sv
package pow_pkg;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_KICK1,
    ST_RUN1,
    ST_KICK2,
    ST_RUN2,
    ST_CHK,
    ST_DONE
  } srch_state_e;

  localparam logic [255:0] SHA_IV =
    256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;

  localparam logic [31:0] RK [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic logic [31:0] rotr32(input logic [31:0] x, input int unsigned n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] big_s0(input logic [31:0] x);
    return rotr32(x, 2) ^ rotr32(x, 13) ^ rotr32(x, 22);
  endfunction

  function automatic logic [31:0] big_s1(input logic [31:0] x);
    return rotr32(x, 6) ^ rotr32(x, 11) ^ rotr32(x, 25);
  endfunction

  function automatic logic [31:0] sml_s0(input logic [31:0] x);
    return rotr32(x, 7) ^ rotr32(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [31:0] sml_s1(input logic [31:0] x);
    return rotr32(x, 17) ^ rotr32(x, 19) ^ (x >> 10);
  endfunction

  function automatic logic [31:0] f_ch(input logic [31:0] e, input logic [31:0] f, input logic [31:0] g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic logic [31:0] f_maj(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

  // A set mask bit demands a zero at that position of the digest's top word.
  function automatic logic mask_clear(input logic [31:0] top_word, input logic [31:0] mask);
    return (top_word & mask) == 32'd0;
  endfunction

endpackage

// File: rtl/pow_hdr_loader.sv
module pow_hdr_loader #(
  parameter int WORDS  = 21,
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [31:0]           wr_data,
  input  logic                  restart,
  output logic                  wr_hit,
  output logic                  complete,
  output logic [WORDS*32-1:0]   words
);

  logic [WORDS-1:0] got;
  logic [WORDS-1:0] got_base;
  logic [WORDS-1:0] got_new;
  logic [WORDS-1:0] sel;

  assign wr_hit = wr_en && (32'(wr_addr) < 32'(WORDS));

  always_comb begin
    sel      = wr_hit ? (WORDS'(1) << wr_addr) : '0;
    got_base = restart ? '0 : got;
    got_new  = got_base | sel;
    complete = wr_hit && (&got_new);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got   <= '0;
      words <= '0;
    end else begin
      if (wr_hit) begin
        got <= complete ? '0 : got_new;
        for (int i = 0; i < WORDS; i++) begin
          if (sel[i]) words[32*i +: 32] <= wr_data;
        end
      end
    end
  end

endmodule

// File: rtl/pow_sha_core.sv
module pow_sha_core
  import pow_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         start,
  input  logic [511:0] blk,
  input  logic [255:0] hin,
  output logic         running,
  output logic         done_p,
  output logic [255:0] hout
);

  logic [31:0] st  [8];
  logic [31:0] ih  [8];
  logic [31:0] w   [16];
  logic [31:0] nxt [8];
  logic [31:0] t1, t2, w_new;
  logic [5:0]  rnd;

  always_comb begin
    t1     = st[7] + big_s1(st[4]) + f_ch(st[4], st[5], st[6]) + RK[rnd] + w[0];
    t2     = big_s0(st[0]) + f_maj(st[0], st[1], st[2]);
    nxt[0] = t1 + t2;
    nxt[1] = st[0];
    nxt[2] = st[1];
    nxt[3] = st[2];
    nxt[4] = st[3] + t1;
    nxt[5] = st[4];
    nxt[6] = st[5];
    nxt[7] = st[6];
    w_new  = sml_s1(w[14]) + w[9] + sml_s0(w[1]) + w[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      done_p  <= 1'b0;
      rnd     <= '0;
      hout    <= '0;
      for (int i = 0; i < 8; i++) begin
        st[i] <= '0;
        ih[i] <= '0;
      end
      for (int i = 0; i < 16; i++) w[i] <= '0;
    end else begin
      done_p <= 1'b0;
      if (clr) begin
        running <= 1'b0;
      end else if (start) begin
        running <= 1'b1;
        rnd     <= '0;
        for (int i = 0; i < 8; i++) begin
          st[i] <= hin[255-32*i -: 32];
          ih[i] <= hin[255-32*i -: 32];
        end
        for (int i = 0; i < 16; i++) w[i] <= blk[511-32*i -: 32];
      end else if (running) begin
        for (int i = 0; i < 8; i++) st[i] <= nxt[i];
        for (int i = 0; i < 15; i++) w[i] <= w[i+1];
        w[15] <= w_new;
        rnd   <= rnd + 6'd1;
        if (rnd == 6'd63) begin
          running <= 1'b0;
          done_p  <= 1'b1;
          for (int i = 0; i < 8; i++) hout[255-32*i -: 32] <= ih[i] + nxt[i];
        end
      end
    end
  end

endmodule

// File: rtl/pow_diff_check.sv
module pow_diff_check
  import pow_pkg::*;
(
  input  logic [255:0] digest,
  input  logic [31:0]  mask,
  output logic         pass
);

  assign pass = mask_clear(digest[255:224], mask);

endmodule

// File: rtl/pow_nonce_search.sv
module pow_nonce_search
  import pow_pkg::*;
#(
  parameter int NONCE_W = 32,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [31:0]       nonce_o,
  output logic [255:0]      digest_o
);

  localparam int MSG_WORDS = 21;
  localparam int NONCE_IDX = 19;
  localparam int MASK_IDX  = 20;
  localparam int MSG_BITS  = 640;
  localparam logic [NONCE_W-1:0] NONCE_MAX = '1;
  localparam logic [31:0] NFIELD = 32'((64'd1 << NONCE_W) - 64'd1);

  srch_state_e             state;
  logic [NONCE_W-1:0]      nonce_q;
  logic [255:0]            mid_q;
  logic [255:0]            digest_q;
  logic                    found_q;

  logic [MSG_WORDS*32-1:0] words;
  logic                    wr_hit;
  logic                    launch;
  logic                    active;
  logic                    abort_evt;
  logic                    core_start;
  logic                    core_busy;
  logic                    core_fin;
  logic [255:0]            core_hout;
  logic [511:0]            blk1, blk2, core_blk;
  logic [255:0]            core_hin;
  logic [31:0]             nonce_word;
  logic [31:0]             mask_w;
  logic                    cand_pass;
  logic                    cand_hit;
  logic                    cand_last_miss;

  assign active     = (state != ST_LOAD);
  assign abort_evt  = wr_hit && active;
  assign mask_w     = words[32*MASK_IDX +: 32];
  assign nonce_word = (words[32*NONCE_IDX +: 32] & ~NFIELD) | 32'(nonce_q);

  pow_hdr_loader #(.WORDS(MSG_WORDS), .ADDR_W(ADDR_W)) u_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .restart  (abort_evt),
    .wr_hit   (wr_hit),
    .complete (launch),
    .words    (words)
  );

  always_comb begin
    for (int i = 0; i < 16; i++) blk1[511-32*i -: 32] = words[32*i +: 32];
    blk2 = {words[32*16 +: 32], words[32*17 +: 32], words[32*18 +: 32], nonce_word,
            32'h8000_0000, 320'd0, 32'(MSG_BITS)};
  end

  assign core_start = (state == ST_KICK1) || (state == ST_KICK2);
  assign core_blk   = (state == ST_KICK1) ? blk1 : blk2;
  assign core_hin   = (state == ST_KICK1) ? SHA_IV : mid_q;

  pow_sha_core u_sha (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (abort_evt),
    .start   (core_start),
    .blk     (core_blk),
    .hin     (core_hin),
    .running (core_busy),
    .done_p  (core_fin),
    .hout    (core_hout)
  );

  pow_diff_check u_diff (
    .digest (digest_q),
    .mask   (mask_w),
    .pass   (cand_pass)
  );

  assign cand_hit       = (state == ST_CHK) && cand_pass;
  assign cand_last_miss = (state == ST_CHK) && !cand_pass && (nonce_q == NONCE_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_LOAD;
      nonce_q  <= '0;
      mid_q    <= '0;
      digest_q <= '0;
      found_q  <= 1'b0;
    end else if (abort_evt) begin
      state    <= ST_LOAD;
      nonce_q  <= '0;
      digest_q <= '0;
      found_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_LOAD: begin
          if (launch) begin
            state   <= ST_KICK1;
            nonce_q <= '0;
            found_q <= 1'b0;
          end
        end
        ST_KICK1: state <= ST_RUN1;
        ST_RUN1: begin
          if (core_fin) begin
            mid_q <= core_hout;
            state <= ST_KICK2;
          end
        end
        ST_KICK2: state <= ST_RUN2;
        ST_RUN2: begin
          if (core_fin) begin
            digest_q <= core_hout;
            state    <= ST_CHK;
          end
        end
        ST_CHK: begin
          if (cand_hit) begin
            found_q <= 1'b1;
            state   <= ST_DONE;
          end else if (cand_last_miss) begin
            state   <= ST_DONE;
          end else begin
            nonce_q <= nonce_q + 1'b1;
            state   <= ST_KICK1;
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  assign busy     = active && (state != ST_DONE);
  assign done     = (state == ST_DONE);
  assign found    = found_q;
  assign nonce_o  = nonce_word;
  assign digest_o = digest_q;

endmodule

// File: rtl/pow_search_chk.sv
module pow_search_chk #(
  parameter int NONCE_W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_hit,
  input logic         launch,
  input logic         abort_evt,
  input logic         core_busy,
  input logic [31:0]  mask_w,
  input logic         busy,
  input logic         done,
  input logic         found,
  input logic [31:0]  nonce_o,
  input logic [255:0] digest_o
);

  localparam logic [NONCE_W-1:0] FIELD_ONES = '1;

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R2
  busy_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch));

  // R8
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!busy && !done && !found));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_hit) |=> (done && !busy && $stable(found) && $stable(nonce_o) && $stable(digest_o)));

  // R5
  match_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> ((digest_o[255:224] & mask_w) == 32'd0));

  // R6
  exhaust_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (nonce_o[NONCE_W-1:0] == FIELD_ONES));

  // R3
  nonce_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((nonce_o == $past(nonce_o)) || (nonce_o == $past(nonce_o) + 32'd1)));

  // R3
  core_in_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_busy |-> busy);

endmodule

bind pow_nonce_search pow_search_chk #(.NONCE_W(NONCE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_hit    (wr_hit),
  .launch    (launch),
  .abort_evt (abort_evt),
  .core_busy (core_busy),
  .mask_w    (mask_w),
  .busy      (busy),
  .done      (done),
  .found     (found),
  .nonce_o   (nonce_o),
  .digest_o  (digest_o)
);

// File: tb/sim_pow_nonce_search.sv
module sim_pow_nonce_search;

  localparam int NW     = 6;
  localparam int PERIOD = 133;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [4:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         busy, done, found;
  logic [31:0]  nonce_o;
  logic [255:0] digest_o;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R9";

  always #5 clk = ~clk;

  pow_nonce_search #(.NONCE_W(NW), .ADDR_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .found(found), .nonce_o(nonce_o), .digest_o(digest_o)
  );

  // ---------------- independent hash model ----------------
  logic [31:0] KB [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] compress(input logic [255:0] hv, input logic [511:0] m);
    logic [31:0] ws [64];
    logic [31:0] a, b, c, d, e, f, g, h, x1, x2;
    for (int t = 0; t < 64; t++) begin
      if (t < 16) ws[t] = m[511-32*t -: 32];
      else ws[t] = (rr(ws[t-2], 17) ^ rr(ws[t-2], 19) ^ (ws[t-2] >> 10)) + ws[t-7]
                 + (rr(ws[t-15], 7) ^ rr(ws[t-15], 18) ^ (ws[t-15] >> 3)) + ws[t-16];
    end
    {a, b, c, d, e, f, g, h} = hv;
    for (int t = 0; t < 64; t++) begin
      x1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + KB[t] + ws[t];
      x2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
      h = g; g = f; f = e; e = d + x1; d = c; c = b; b = a; a = x1 + x2;
    end
    return {hv[255:224] + a, hv[223:192] + b, hv[191:160] + c, hv[159:128] + d,
            hv[127:96] + e, hv[95:64] + f, hv[63:32] + g, hv[31:0] + h};
  endfunction

  logic [31:0]  mh [21];
  logic [20:0]  mgot;
  bit           mbusy, mdone, mfound;
  int           mcd;
  logic [31:0]  mnonce, pnonce;
  logic [255:0] mdig, pdig;
  bit           pfound;

  // R4 R5 R6: search the held header with the bench's own hash model
  task automatic model_search(output int k, output bit f, output logic [31:0] nw, output logic [255:0] dg);
    logic [511:0] b1, b2;
    logic [255:0] iv, mid;
    iv = 256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;
    f = 0;
    k = 0;
    for (int i = 0; i < 16; i++) b1[511-32*i -: 32] = mh[i];
    for (int n = 0; n < (1 << NW); n++) begin
      k  = n;
      nw = (mh[19] & ~32'((1 << NW) - 1)) | 32'(n);
      b2 = {mh[16], mh[17], mh[18], nw, 32'h8000_0000, 320'd0, 32'd640};
      mid = compress(iv, b1);
      dg  = compress(mid, b2);
      if ((dg[255:224] & mh[20]) == 32'd0) begin
        f = 1;
        break;
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mgot = '0; mbusy = 0; mdone = 0; mfound = 0; mcd = 0;
      mnonce = '0; mdig = '0;
    end else if (wr_en && wr_addr <= 5'd20) begin
      int k;
      if (mbusy || mdone) begin          // R8 abort
        mbusy = 0; mdone = 0; mfound = 0; mgot = '0;
      end
      mh[wr_addr] = wr_data;
      mgot[wr_addr] = 1'b1;
      if (&mgot) begin                   // R2 launch
        mgot = '0;
        model_search(k, pfound, pnonce, pdig);
        mbusy = 1;
        mcd = PERIOD * (k + 1);          // R3 timing
      end
    end else if (mbusy) begin
      mcd--;
      if (mcd == 0) begin
        mbusy = 0; mdone = 1; mfound = pfound; mnonce = pnonce; mdig = pdig;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "busy", 256'(busy), 256'(mbusy));
      chk(cur_req, "done", 256'(done), 256'(mdone));
      chk("R10", "busy&done", 256'(busy && done), 256'd0);
      if (mdone) begin
        chk(mfound ? "R5" : "R6", "found", 256'(found), 256'(mfound));
        chk(mfound ? "R5" : "R6", "nonce", 256'(nonce_o), 256'(mnonce));
        chk("R4", "digest", digest_o, mdig);
      end
    end
  end

  function automatic logic [31:0] hw(input int seed, input int i);
    return (32'(seed) * 32'h9E3779B9) ^ (32'(i) * 32'h85EBCA6B) ^ 32'(i + 7);
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  task automatic load(input int seed, input logic [31:0] mask);
    for (int i = 0; i < 20; i++) wr(i, hw(seed, i));
    wr(20, mask);
    idle(1);
  endtask

  task automatic wait_done();
    while (!mdone) @(negedge clk);
    idle(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9", "busy", 256'(busy), 256'd0);
    chk("R9", "done", 256'(done), 256'd0);
    chk("R9", "found", 256'(found), 256'd0);
    rst_n = 1'b1;

    // R1 / R2: duplicates and out-of-range addresses do not complete a load
    cur_req = "R2";
    for (int i = 0; i < 19; i++) wr(i, hw(1, i));
    wr(5, hw(1, 5));
    wr(20, 32'h8000_0000);
    wr(25, 32'hdead_beef);
    idle(5);
    chk("R1", "busy after stray addr", 256'(busy), 256'd0);
    chk("R2", "busy with word 19 missing", 256'(busy), 256'd0);
    wr(19, hw(1, 19));
    idle(1);
    chk("R2", "busy after completing write", 256'(busy), 256'd1);
    cur_req = "R3";
    wait_done();

    // R4: mask zero accepts candidate 0 after one period
    cur_req = "R4";
    load(2, 32'h0000_0000);
    wait_done();
    chk("R4", "found on mask 0", 256'(found), 256'd1);
    chk("R4", "nonce field 0", 256'(nonce_o[NW-1:0]), 256'd0);

    // R6: full mask exhausts the field
    cur_req = "R6";
    load(3, 32'hFFFF_FFFF);
    wait_done();

    // R1: reverse-order load, stray high address during search
    cur_req = "R1";
    for (int i = 20; i >= 0; i--) wr(i, (i == 20) ? 32'hC000_0000 : hw(4, i));
    idle(40);
    wr(31, 32'h1234_5678);
    idle(1);
    chk("R1", "busy kept after addr 31", 256'(busy), 256'd1);
    wait_done();

    // R7: result holds while nothing is written
    cur_req = "R7";
    idle(60);
    chk("R7", "done held", 256'(done), 256'd1);

    // R8: abort from done, then abort mid-search
    cur_req = "R8";
    load(5, 32'hF800_0000);
    idle(300);
    wr(3, hw(6, 3));
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8", "busy after abort", 256'(busy), 256'd0);
    chk("R8", "found after abort", 256'(found), 256'd0);
    for (int i = 0; i < 20; i++) if (i != 3) wr(i, hw(6, i));
    wr(20, 32'hE000_0000);
    idle(1);
    chk("R8", "busy after reload", 256'(busy), 256'd1);
    cur_req = "R5";
    wait_done();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule